// File: doc/BRIEF.md
# Chained Performance Event Counter Bank

A bank of programmable 32-bit event counters with a free-running 64-bit cycle counter in the last slot (index 31). Each event counter has a type register. A counter advances when its selected event fires: either a pulse on the matching bit of a per-event input vector, a write to the software-increment register, or a wrap of its even-indexed neighbour. Software drives the whole bank through a simple register port. Writes are synchronous, and reads are a combinational decode of the read address.

A control register holds a global enable, a long-cycle-counter bit and two self-clearing reset commands. It also reports, read-only, how many event counters exist. Enable, interrupt-enable and overflow masks have separate set and clear addresses. A level overflow interrupt is raised whenever an enabled counter with its interrupt enabled has an overflow recorded. When an even counter wraps, a chain event is presented to its odd partner, so a pair can be used as one 64-bit count.

Register word addresses (7 bits): 0x00 control, 0x01/0x02 count-enable set/clear, 0x03/0x04 interrupt-enable set/clear, 0x05 overflow clear (reads overflow status), 0x06 software increment, 0x08/0x09 cycle counter low/high, 0x20+i event counter i, 0x40+i type of counter i. Control bits: bit 0 global enable, bit 1 clear event counters, bit 2 clear cycle counter, bit 3 long cycle counter, bits 12:8 counter count N. Event code 0x000 is software increment, and 0x01E is chain.

Top module: `perf_ctr_bank`

## Requirements
- R1: With control bit 0 clear, no counter advances and `irq` is low, whatever the status bits hold.
- R2: A counter advances only while its bit is set in the count-enable mask (reads at 0x01 or 0x02).
- R3: Event counters are 32 bits. An increment that wraps a counter past 0xFFFFFFFF sets its bit in the overflow status. Writing ones to 0x05 clears those status bits.
- R4: When even counter i wraps and counter i+1 exists, counter i+1 receives one chain event in the same clock. It counts that event only if it is enabled and its type is 0x01E. Odd counters never chain onward.
- R5: Writing a mask to 0x06 increments every selected, enabled event counter whose type is 0x000. Overflow and chaining follow R3 and R4.
- R6: Type writes keep only the event field: 16 bits with WIDE_EVT=1, 10 bits otherwise. Higher bits read back zero.
- R7: `irq` is the OR of (overflow AND count-enable AND interrupt-enable), gated by the global enable.
- R8: Writing control bit 2 zeroes the cycle counter. Writing control bit 1 zeroes all event counters but not the cycle counter. Neither bit is stored, and both read back zero.
- R9: The 64-bit cycle counter advances once per clock while enabled (mask bit 31). It flags overflow on a 32-bit wrap when control bit 3 is clear, and on a 64-bit wrap when it is set.
- R10: Control bits 12:8 read N, the number of event counters. Mask bits other than 0..N-1 and 31 are never set, and writes to counters that do not exist are ignored.
- R11: A counter whose type t is below EVT_IN advances by one on each clock where `evt_in[t]` is high. Pulses for other events are ignored.
- R12: A hardware pulse and a software increment landing on the same counter in the same clock advance it by two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 7 | Write word address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 7 | Read word address |
| evt_in | input | EVT_IN | One pulse line per hardware event code |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| irq | output | 1 | Level overflow interrupt |

## Verification
Every register write, event pulse and software increment takes effect at the rising edge where it is presented. A chained increment of the odd partner lands in that same edge. The interrupt level follows one edge after the status change that causes it. The bench drives each stimulus for exactly one clock from a falling edge, then reads back on the next falling edge, so every expected value is due exactly where it is sampled. The cycle counter advances each clock, so its exact values are taken only after its enable is cleared. While it runs, only bounds are checked.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
   localparam int ADDR_W = 7;
   localparam logic [ADDR_W-1:0] A_CTRL    = 7'h00;
   localparam logic [ADDR_W-1:0] A_CEN_SET = 7'h01;
   localparam logic [ADDR_W-1:0] A_CEN_CLR = 7'h02;
   localparam logic [ADDR_W-1:0] A_IEN_SET = 7'h03;
   localparam logic [ADDR_W-1:0] A_IEN_CLR = 7'h04;
   localparam logic [ADDR_W-1:0] A_OVF_CLR = 7'h05;
   localparam logic [ADDR_W-1:0] A_SWINC   = 7'h06;
   localparam logic [ADDR_W-1:0] A_CYC_LO  = 7'h08;
   localparam logic [ADDR_W-1:0] A_CYC_HI  = 7'h09;
   localparam int A_CNT_BASE = 'h20;
   localparam int A_TYP_BASE = 'h40;
   localparam int B_EN = 0;
   localparam int B_PCLR = 1;
   localparam int B_CCLR = 2;
   localparam int B_LONG = 3;
   localparam int N_LSB = 8;
   localparam int TYP_W = 16;
   localparam int CYC_IDX = 31;
   localparam logic [TYP_W-1:0] EV_SWINC = 16'h0000;
   localparam logic [TYP_W-1:0] EV_CHAIN = 16'h001E;

   function automatic logic [TYP_W-1:0] evt_field_mask(input bit wide);
      return wide ? 16'hFFFF : 16'h03FF;
   endfunction
endpackage

// File: rtl/pmc_event_ctr.sv
module pmc_event_ctr
   import pmc_pkg::*;
#(
   parameter int EVT_IN = 8,
   parameter bit WIDE_EVT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              glb_en,
   input  logic              cnt_en,
   input  logic [EVT_IN-1:0] evt_in,
   input  logic              sw_hit,
   input  logic              chain_hit,
   input  logic              wr_cnt,
   input  logic              wr_typ,
   input  logic              clr,
   input  logic [31:0]       wr_data,
   output logic [31:0]       cnt_q,
   output logic [TYP_W-1:0]  typ_q,
   output logic              wrap_o
);
   localparam int IW = (EVT_IN > 1) ? $clog2(EVT_IN) : 1;
   localparam logic [TYP_W-1:0] TMASK = evt_field_mask(WIDE_EVT);

   logic       live, hw_inc, sw_inc, ch_inc;
   logic [1:0] step;
   logic [32:0] sum;

   assign live   = glb_en & cnt_en;
   assign hw_inc = live && (typ_q < TYP_W'(EVT_IN)) && evt_in[typ_q[IW-1:0]];
   assign sw_inc = live & sw_hit & (typ_q == EV_SWINC);
   assign ch_inc = live & chain_hit & (typ_q == EV_CHAIN);
   assign step   = {1'b0, hw_inc} + {1'b0, sw_inc} + {1'b0, ch_inc};
   assign sum    = {1'b0, cnt_q} + {31'b0, step};
   assign wrap_o = sum[32] & ~wr_cnt & ~clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         typ_q <= '0;
      end else begin
         if (clr)         cnt_q <= '0;
         else if (wr_cnt) cnt_q <= wr_data;
         else             cnt_q <= sum[31:0];
         if (wr_typ)      typ_q <= wr_data[TYP_W-1:0] & TMASK;
      end
   end

   // R1
   hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!glb_en && !wr_cnt && !clr) |=> $stable(cnt_q));
   // R8
   p_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt_q == '0));
   // R3
   wrap_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_o |=> (cnt_q <= 32'd1));
endmodule

// File: rtl/pmc_cycle_ctr.sv
module pmc_cycle_ctr (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        run,
   input  logic        long_mode,
   input  logic        clr,
   input  logic        wr_lo,
   input  logic        wr_hi,
   input  logic [31:0] wr_data,
   output logic [63:0] cyc_q,
   output logic        wrap_o
);
   logic quiet;
   assign quiet  = ~clr & ~wr_lo & ~wr_hi;
   assign wrap_o = run & quiet & (long_mode ? (&cyc_q) : (&cyc_q[31:0]));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cyc_q <= '0;
      else if (clr)    cyc_q <= '0;
      else if (wr_lo)  cyc_q <= {cyc_q[63:32], wr_data};
      else if (wr_hi)  cyc_q <= {wr_data, cyc_q[31:0]};
      else if (run)    cyc_q <= cyc_q + 64'd1;
   end

   // R9
   cyc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && quiet) |=> (cyc_q == $past(cyc_q) + 64'd1));
   // R8
   c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cyc_q == '0));
endmodule

// File: rtl/perf_ctr_bank.sv
module perf_ctr_bank
   import pmc_pkg::*;
#(
   parameter int N_EVT = 4,
   parameter int EVT_IN = 8,
   parameter bit WIDE_EVT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [6:0]        wr_addr,
   input  logic [31:0]       wr_data,
   input  logic [6:0]        rd_addr,
   input  logic [EVT_IN-1:0] evt_in,
   output logic [31:0]       rd_data,
   output logic              irq
);
   localparam logic [31:0] VALID = ((32'h1 << N_EVT) - 32'h1) | 32'h8000_0000;

   if (N_EVT < 1 || N_EVT > 31) begin : g_bad_n
      $error("N_EVT must lie in 1..31");
   end
   if (EVT_IN < 2 || EVT_IN > 16) begin : g_bad_in
      $error("EVT_IN must lie in 2..16");
   end

   logic        ctl_e, ctl_lc;
   logic [31:0] cen_q, ien_q, ovf_q, wrap_vec;
   logic        wr_ctl, p_clr, c_clr;
   logic [31:0] sw_mask, dmask;
   logic [63:0] cyc_q;
   logic        cyc_wrap;
   logic [31:0] cnt_q [N_EVT];
   logic [TYP_W-1:0] typ_q [N_EVT];
   logic [N_EVT-1:0] wrap, wr_cnt, wr_typ, chain_in;

   assign dmask   = wr_data & VALID;
   assign wr_ctl  = wr_en && (wr_addr == A_CTRL);
   assign p_clr   = wr_ctl & wr_data[B_PCLR];
   assign c_clr   = wr_ctl & wr_data[B_CCLR];
   assign sw_mask = (wr_en && wr_addr == A_SWINC) ? (dmask & 32'h7FFF_FFFF) : '0;

   for (genvar i = 0; i < N_EVT; i++) begin : g_ctr
      assign wr_cnt[i] = wr_en && (wr_addr == 7'(A_CNT_BASE + i));
      assign wr_typ[i] = wr_en && (wr_addr == 7'(A_TYP_BASE + i));
      if (i % 2 == 1) begin : g_odd
         assign chain_in[i] = wrap[i-1];
         // R4
         chain_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wrap[i-1] && ctl_e && cen_q[i] && typ_q[i] == EV_CHAIN && !wr_cnt[i] && !p_clr)
            |=> (cnt_q[i] == $past(cnt_q[i]) + 32'd1));
      end else begin : g_even
         assign chain_in[i] = 1'b0;
      end
      pmc_event_ctr #(.EVT_IN(EVT_IN), .WIDE_EVT(WIDE_EVT)) u_ctr (
         .clk(clk), .rst_n(rst_n), .glb_en(ctl_e), .cnt_en(cen_q[i]),
         .evt_in(evt_in), .sw_hit(sw_mask[i]), .chain_hit(chain_in[i]),
         .wr_cnt(wr_cnt[i]), .wr_typ(wr_typ[i]), .clr(p_clr),
         .wr_data(wr_data), .cnt_q(cnt_q[i]), .typ_q(typ_q[i]), .wrap_o(wrap[i]));
      // R3
      ovf_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
         wrap[i] |=> ovf_q[i]);
   end

   pmc_cycle_ctr u_cyc (
      .clk(clk), .rst_n(rst_n), .run(ctl_e & cen_q[CYC_IDX]), .long_mode(ctl_lc),
      .clr(c_clr), .wr_lo(wr_en && wr_addr == A_CYC_LO),
      .wr_hi(wr_en && wr_addr == A_CYC_HI), .wr_data(wr_data),
      .cyc_q(cyc_q), .wrap_o(cyc_wrap));

   always_comb begin
      wrap_vec = '0;
      wrap_vec[N_EVT-1:0] = wrap;
      wrap_vec[CYC_IDX] = cyc_wrap;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_e <= 1'b0;
         ctl_lc <= 1'b0;
         cen_q <= '0;
         ien_q <= '0;
         ovf_q <= '0;
      end else begin
         if (wr_ctl) begin
            ctl_e  <= wr_data[B_EN];
            ctl_lc <= wr_data[B_LONG];
         end
         if (wr_en && wr_addr == A_CEN_SET) cen_q <= cen_q | dmask;
         if (wr_en && wr_addr == A_CEN_CLR) cen_q <= cen_q & ~dmask;
         if (wr_en && wr_addr == A_IEN_SET) ien_q <= ien_q | dmask;
         if (wr_en && wr_addr == A_IEN_CLR) ien_q <= ien_q & ~dmask;
         if (wr_en && wr_addr == A_OVF_CLR) ovf_q <= (ovf_q & ~dmask) | wrap_vec;
         else                               ovf_q <= ovf_q | wrap_vec;
      end
   end

   assign irq = ctl_e & (|(ovf_q & cen_q & ien_q));

   always_comb begin
      rd_data = '0;
      case (rd_addr)
         A_CTRL:               rd_data = (32'(N_EVT) << N_LSB) | (32'(ctl_lc) << B_LONG) | 32'(ctl_e);
         A_CEN_SET, A_CEN_CLR: rd_data = cen_q;
         A_IEN_SET, A_IEN_CLR: rd_data = ien_q;
         A_OVF_CLR:            rd_data = ovf_q;
         A_CYC_LO:             rd_data = cyc_q[31:0];
         A_CYC_HI:             rd_data = cyc_q[63:32];
         default:              rd_data = '0;
      endcase
      for (int k = 0; k < N_EVT; k++) begin
         if (rd_addr == 7'(A_CNT_BASE + k)) rd_data = cnt_q[k];
         if (rd_addr == 7'(A_TYP_BASE + k)) rd_data = {16'b0, typ_q[k]};
      end
   end

   // R10
   valid_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((cen_q | ien_q | ovf_q) & ~VALID) == '0);
   // R1
   irq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctl && !wr_data[B_EN]) |=> !irq);
endmodule

// File: tb/tb_perf_ctr_bank.sv
`timescale 1ns/1ps
module tb_perf_ctr_bank;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [6:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [6:0]  rd_addr = '0;
   logic [7:0]  evt_in = '0;
   logic [31:0] rd_data;
   logic        irq;
   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;
   logic [31:0] v;

   perf_ctr_bank dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .evt_in(evt_in), .rd_data(rd_data), .irq(irq));

   always #5 clk = ~clk;

   task automatic wr(input logic [6:0] a, input logic [31:0] d);
      @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(input logic [6:0] a, output logic [31:0] d);
      rd_addr = a; #1; d = rd_data;
   endtask

   task automatic pulse(input logic [7:0] e);
      @(negedge clk); evt_in = e;
      @(negedge clk); evt_in = '0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic chk_rd(input string tag, input logic [6:0] a, input logic [31:0] exp);
      logic [31:0] d;
      rd(a, d);
      chk(tag, d, exp);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      idle(2); rst_n = 1'b1; idle(1);
      // reset state, R10 count field
      chk_rd("R10 ctrl reset", 7'h00, 32'h0000_0400);
      chk_rd("R2 cen reset", 7'h01, 32'h0);
      chk_rd("R3 ovf reset", 7'h05, 32'h0);
      chk("R7 irq reset", {31'b0, irq}, 32'h0);
      // R6 type mask
      wr(7'h40, 32'h0001_1234);
      chk_rd("R6 type mask", 7'h40, 32'h0000_1234);
      // R1 no count with global enable off
      wr(7'h40, 32'd3); wr(7'h01, 32'h1);
      pulse(8'h08);
      chk_rd("R1 gated count", 7'h20, 32'd0);
      // R11 hardware events
      wr(7'h00, 32'h1);
      for (int k = 0; k < 5; k++) pulse(8'h08);
      chk_rd("R11 five pulses", 7'h20, 32'd5);
      pulse(8'h10);
      chk_rd("R11 other event", 7'h20, 32'd5);
      // R2 disabled counter
      wr(7'h41, 32'd3);
      pulse(8'h08);
      chk_rd("R2 disabled ctr", 7'h21, 32'd0);
      chk_rd("R2 enabled ctr", 7'h20, 32'd6);
      // R3 overflow, R7 irq
      wr(7'h20, 32'hFFFF_FFFF);
      pulse(8'h08);
      chk_rd("R3 wrap value", 7'h20, 32'd0);
      chk_rd("R3 ovf bit", 7'h05, 32'h1);
      chk("R7 irq masked", {31'b0, irq}, 32'h0);
      wr(7'h03, 32'h1);
      chk("R7 irq raised", {31'b0, irq}, 32'h1);
      wr(7'h00, 32'h0);
      chk("R1 irq gated", {31'b0, irq}, 32'h0);
      wr(7'h00, 32'h1);
      chk("R7 irq back", {31'b0, irq}, 32'h1);
      wr(7'h05, 32'h1);
      chk_rd("R3 ovf cleared", 7'h05, 32'h0);
      chk("R7 irq after clear", {31'b0, irq}, 32'h0);
      // R4 chaining
      wr(7'h41, 32'h1E); wr(7'h01, 32'h2);
      wr(7'h20, 32'hFFFF_FFFF);
      pulse(8'h08);
      chk_rd("R4 chained +1", 7'h21, 32'd1);
      chk_rd("R4 ovf only even", 7'h05, 32'h1);
      wr(7'h05, 32'hFFFF_FFFF);
      wr(7'h41, 32'd5); wr(7'h20, 32'hFFFF_FFFF);
      pulse(8'h08);
      chk_rd("R4 wrong type", 7'h21, 32'd1);
      wr(7'h41, 32'h1E); wr(7'h21, 32'hFFFF_FFFF); wr(7'h20, 32'hFFFF_FFFF);
      pulse(8'h08);
      chk_rd("R4 odd wraps", 7'h21, 32'd0);
      chk_rd("R4 pair ovf", 7'h05, 32'h3);
      wr(7'h05, 32'h3);
      // R5 software increment
      wr(7'h40, 32'h0); wr(7'h42, 32'h0); wr(7'h01, 32'h4);
      wr(7'h20, 32'd10);
      wr(7'h06, 32'hF);
      chk_rd("R5 swinc ctr0", 7'h20, 32'd11);
      chk_rd("R5 swinc chain type", 7'h21, 32'd0);
      chk_rd("R5 swinc ctr2", 7'h22, 32'd1);
      chk_rd("R5 swinc disabled", 7'h23, 32'd0);
      wr(7'h20, 32'hFFFF_FFFF);
      wr(7'h06, 32'h1);
      chk_rd("R5 swinc chains", 7'h21, 32'd1);
      wr(7'h05, 32'hFFFF_FFFF);
      // R12 simultaneous hardware + software
      @(negedge clk); evt_in = 8'h01; wr_en = 1'b1; wr_addr = 7'h06; wr_data = 32'h4;
      @(negedge clk); evt_in = '0; wr_en = 1'b0;
      chk_rd("R12 plus two", 7'h22, 32'd3);
      // R8 commands
      wr(7'h01, 32'h8000_0000);
      idle(10);
      wr(7'h00, 32'h5);
      chk_rd("R8 ctrl no C", 7'h00, 32'h0000_0401);
      rd(7'h08, v);
      chk("R8 cycle cleared", {31'b0, (v <= 32'd2)}, 32'h1);
      idle(20);
      wr(7'h00, 32'h3);
      chk_rd("R8 P clears ctr0", 7'h20, 32'd0);
      chk_rd("R8 P clears ctr2", 7'h22, 32'd0);
      rd(7'h08, v);
      chk("R8 P keeps cycle", {31'b0, (v >= 32'd20)}, 32'h1);
      // R9 cycle overflow, short mode
      wr(7'h02, 32'h8000_0000);
      wr(7'h05, 32'hFFFF_FFFF);
      wr(7'h08, 32'hFFFF_FFF0); wr(7'h09, 32'h0);
      wr(7'h01, 32'h8000_0000); idle(40); wr(7'h02, 32'h8000_0000);
      chk_rd("R9 short ovf", 7'h05, 32'h8000_0000);
      chk_rd("R9 carry high", 7'h09, 32'h1);
      wr(7'h05, 32'hFFFF_FFFF);
      // R9 long mode
      wr(7'h00, 32'h9);
      wr(7'h08, 32'hFFFF_FFF0); wr(7'h09, 32'h0);
      wr(7'h01, 32'h8000_0000); idle(40); wr(7'h02, 32'h8000_0000);
      chk_rd("R9 long no ovf", 7'h05, 32'h0);
      chk_rd("R9 long carry", 7'h09, 32'h1);
      wr(7'h08, 32'hFFFF_FFF0); wr(7'h09, 32'hFFFF_FFFF);
      wr(7'h01, 32'h8000_0000); idle(40); wr(7'h02, 32'h8000_0000);
      chk_rd("R9 long ovf", 7'h05, 32'h8000_0000);
      chk_rd("R9 long wrap high", 7'h09, 32'h0);
      // R10 unimplemented bits
      wr(7'h01, 32'hFFFF_FFFF);
      chk_rd("R10 cen valid", 7'h01, 32'h8000_000F);
      wr(7'h03, 32'hFFFF_FFFF);
      chk_rd("R10 ien valid", 7'h03, 32'h8000_000F);
      wr(7'h25, 32'd7);
      chk_rd("R10 absent ctr", 7'h25, 32'd0);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule